// File: doc/BRIEF.md
# Receive Interrupt Pin Controller

This block owns the receive byte buffer of a serial port and turns its fill state into the level of the receive interrupt pin. A byte producer pushes received characters through a write port, and a consumer pops them through a read port that always shows the oldest byte. The block keeps the occupancy count and compares it against the request condition.

A buffer-mode input selects between two request rules. With buffering off, the store holds exactly one byte, and a request is raised while that byte waits. With buffering on, the store is a 16-entry queue, and a request is raised while the fill level is at or above a selectable threshold. A polarity input makes the pin either an active-high interrupt or an active-low request line. Toggling the buffer-mode input empties the store. A write that finds the store full is lost and latches a sticky overrun flag.

Top module: `rxirq_ctrl`

## Requirements
- R1: After reset, count is 0, overrun is 0, and irq_pin is at its idle level.
- R2: With buf_on=0, the store holds one byte. A write while one byte is held is dropped, and rd_data keeps the first byte.
- R3: With buf_on=0, a request is raised while count is 1 and is removed while count is 0.
- R4: With buf_on=1, the store holds up to 16 bytes and returns them in write order on rd_data. rd_data shows the oldest byte while count is nonzero.
- R5: With buf_on=1, a request is raised while count is greater than or equal to the threshold. thr_sel encodes the threshold as 00=1, 01=4, 10=8 and 11=14.
- R6: A read with count nonzero lowers count by one in the next cycle. The pin leaves the request level in that same cycle if count then falls below the threshold.
- R7: With act_high=1, irq_pin is 1 for a request and 0 for idle. With act_high=0, irq_pin is 0 for a request and 1 for idle.
- R8: A write while count equals the capacity (1 or 16) leaves count unchanged and sets overrun. overrun then stays 1 until reset.
- R9: A cycle in which buf_on differs from its value in the previous cycle empties the store, so count is 0 after it. Any write or read in that cycle is ignored.
- R10: A read while count is 0 leaves count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_on | input | 1 | 1 selects the 16-entry queue, 0 selects the single-byte holding register |
| thr_sel | input | 2 | Threshold code used when buf_on=1 |
| act_high | input | 1 | Pin polarity: 1 active-high, 0 active-low |
| wr_en | input | 1 | Push wr_data into the store |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest held byte |
| count | output | 5 | Bytes currently held |
| overrun | output | 1 | Sticky flag for a lost write |
| irq_pin | output | 1 | Receive interrupt pin level |

## Verification
The assertions assume that every input is driven to a known value from reset onward. They also assume that buf_on changes only between clock edges, so a flush is seen as a single clean cycle. The stimulus changes inputs only on falling edges and keeps them at 0 or 1 at all times. For every mode, threshold and polarity, it fills the store past capacity and then drains it past empty. This reaches the full-drop, empty-read and flush corners without leaving the defined input space.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

   // Threshold table for a queue of the given depth, indexed by the 2-bit code.
   function automatic int unsigned thr_level(input int unsigned depth, input int unsigned idx);
      case (idx)
         0:       return 1;
         1:       return depth / 4;
         2:       return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/rxirq_store.sv
module rxirq_store #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          buf_on,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count,
   output logic          overrun,
   output logic          mode_q
);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic [CW-1:0] cap;
   logic          flush, full, wr_ok, rd_ok;

   assign flush = buf_on ^ mode_q;
   assign cap   = mode_q ? CW'(DEPTH) : CW'(1);
   assign full  = (count == cap);
   assign wr_ok = wr_en && !full && !flush;
   assign rd_ok = rd_en && (count != '0) && !flush;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wr_data;
   end

   assign rd_data = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         mode_q <= buf_on;
         if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
         end else begin
            if (wr_ok) wptr <= wptr + PW'(1);
            if (rd_ok) rptr <= rptr + PW'(1);
            case ({wr_ok, rd_ok})
               2'b10:   count <= count + CW'(1);
               2'b01:   count <= count - CW'(1);
               default: count <= count;
            endcase
         end
         if (wr_en && full && !flush) overrun <= 1'b1;
      end
   end

   // R4: occupancy never passes the capacity of the selected mode
   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= cap);

   // R8: overrun is sticky
   p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R8: a write into a full store without a read is lost
   p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en && !flush) |=> (count == $past(count)) && overrun);

   // R9: a mode change empties the store
   p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_on != mode_q) |=> (count == '0));

   // R6: a lone read lowers the count by one
   p_read_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && count != '0 && !flush) |=> (count == $past(count) - CW'(1)));

   // R10: a read of an empty store is ignored
   p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && count == '0) |=> (count == '0));

endmodule

// File: rtl/rxirq_level.sv
module rxirq_level #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW   = $clog2(DEPTH + 1),
   localparam int unsigned NLVL = 4
) (
   input  logic          mode_q,
   input  logic [1:0]    thr_sel,
   input  logic [CW-1:0] count,
   output logic          req
);
   import rxirq_pkg::*;

   logic [CW-1:0] lvl [NLVL];

   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      assign lvl[g] = CW'(thr_level(DEPTH, g));
   end

   always_comb begin
      if (mode_q) req = (count >= lvl[thr_sel]);
      else        req = (count != '0);
   end

endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          buf_on,
   input  logic [1:0]    thr_sel,
   input  logic          act_high,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count,
   output logic          overrun,
   output logic          irq_pin
);

   initial begin
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0)
         $error("rxirq_ctrl: DEPTH must be a power of two of at least 8");
      if (DW < 1)
         $error("rxirq_ctrl: DW must be positive");
   end

   logic mode_q, req;

   rxirq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .buf_on(buf_on),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .count(count), .overrun(overrun), .mode_q(mode_q)
   );

   rxirq_level #(.DEPTH(DEPTH)) u_level (
      .mode_q(mode_q), .thr_sel(thr_sel), .count(count), .req(req)
   );

   assign irq_pin = act_high ? req : !req;

   // R7 / R3: an empty store always shows the idle level
   p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> (irq_pin == !act_high));

   // R5: a full queue is above every threshold
   p_full_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && count == CW'(DEPTH)) |-> (irq_pin == act_high));

   // R3: a held byte in holding mode requests
   p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && count != '0) |-> (irq_pin == act_high));

endmodule

// File: tb/sim_rxirq_ctrl.sv
`timescale 1ns/1ps
module sim_rxirq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       buf_on = 1'b0;
   logic [1:0] thr_sel = 2'b00;
   logic       act_high = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [4:0] count;
   logic       overrun;
   logic       irq_pin;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   bit exp_ovr = 0;

   always #2 clk = ~clk;

   rxirq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .buf_on(buf_on), .thr_sel(thr_sel),
      .act_high(act_high), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .count(count), .overrun(overrun), .irq_pin(irq_pin)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic [7:0] d, input logic r);
      @(negedge clk);
      wr_en = w; wr_data = d; rd_en = r;
      @(posedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic flip(input logic w);
      @(negedge clk);
      buf_on = !buf_on; wr_en = w; wr_data = 8'hEE; rd_en = w;
      @(posedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   function automatic int lvl_of(input int s);
      case (s)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic logic pin_of(input bit req, input logic ah);
      return ah ? req : !req;
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(count == 0, "R1 count", count, 0);
      chk(overrun == 0, "R1 overrun", overrun, 0);
      chk(irq_pin == 1'b0, "R1 pin idle", irq_pin, 0);

      // Holding mode, both polarities
      for (int ah = 0; ah < 2; ah++) begin
         act_high = ah[0];
         #1;
         chk(irq_pin == pin_of(0, act_high), "R7 idle", irq_pin, pin_of(0, act_high));
         step(1, 8'h3C + 8'(ah), 0);
         chk(count == 1, "R2 one byte", count, 1);
         chk(irq_pin == pin_of(1, act_high), "R3 request", irq_pin, pin_of(1, act_high));
         step(1, 8'h99, 0);
         exp_ovr = 1;
         chk(count == 1, "R2 second dropped", count, 1);
         chk(rd_data == 8'h3C + 8'(ah), "R2 data kept", rd_data, 8'h3C + ah);
         chk(overrun == exp_ovr, "R8 overrun", overrun, exp_ovr);
         step(0, 8'h00, 1);
         chk(count == 0, "R6 read", count, 0);
         chk(irq_pin == pin_of(0, act_high), "R3 cleared", irq_pin, pin_of(0, act_high));
         step(0, 8'h00, 1);
         chk(count == 0, "R10 empty read", count, 0);
      end

      // Enter queue mode with a write in the change cycle
      flip(1);
      chk(count == 0, "R9 write ignored on change", count, 0);

      for (int s = 0; s < 4; s++) begin
         for (int ah = 0; ah < 2; ah++) begin
            int mc;
            int lv;
            thr_sel = 2'(s);
            act_high = ah[0];
            lv = lvl_of(s);
            mc = 0;
            for (int i = 0; i < 17; i++) begin
               step(1, 8'(s * 40 + ah * 20 + i), 0);
               if (mc < 16) mc++;
               else exp_ovr = 1;
               chk(int'(count) == mc, "R4 fill count", count, mc);
               chk(irq_pin == pin_of(mc >= lv, act_high), "R5 fill pin",
                   irq_pin, pin_of(mc >= lv, act_high));
               chk(overrun == exp_ovr, "R8 overrun", overrun, exp_ovr);
            end
            for (int i = 0; i < 16; i++) begin
               chk(rd_data == 8'(s * 40 + ah * 20 + i), "R4 order", rd_data,
                   8'(s * 40 + ah * 20 + i));
               step(0, 8'h00, 1);
               mc--;
               chk(int'(count) == mc, "R6 drain count", count, mc);
               chk(irq_pin == pin_of(mc >= lv, act_high), "R6 drain pin",
                   irq_pin, pin_of(mc >= lv, act_high));
            end
            step(0, 8'h00, 1);
            chk(count == 0, "R10 empty read", count, 0);
            // Flush with data held, out to holding mode and back
            for (int i = 0; i < 5; i++) step(1, 8'(i), 0);
            chk(count == 5, "R9 preload", count, 5);
            flip(0);
            chk(count == 0, "R9 flush to hold", count, 0);
            chk(irq_pin == pin_of(0, act_high), "R9 pin idle", irq_pin, pin_of(0, act_high));
            step(1, 8'h11, 0);
            flip(1);
            chk(count == 0, "R9 flush to queue", count, 0);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule